// File: doc/BRIEF.md
# Security-Gated Interrupt State Bitmaps

This block holds the per-interrupt enable, pending and active state of the shared interrupts in an interrupt distributor. Each of the three bitmaps appears twice in the register space. One alias sets bits when 1s are written to it. The other alias clears bits when 1s are written to it. Reading either alias returns the same view of the bitmap.

Beside the three bitmaps the block stores four more things per interrupt:
- a group bit;
- a trigger bit (edge or level);
- a 2-bit non-secure permission code;
- the sampled level of the interrupt's input line.

A non-secure access made while security is in force only reaches the bits that it is permitted to reach. A bit is permitted when its interrupt is in the non-secure group, or when its permission code meets the threshold that the register alias requires. A secure access reaches every bit. When the `sec_disable` pin is high, every access reaches every bit.

Software reaches the block through one 32-bit register port. The port follows a valid/ready convention. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high, and the requester never sees back-pressure. A read returns `rsp_valid` with `rsp_rdata` exactly one cycle after the read request. A write returns no response. The response side has no ready signal, so the consumer must take the data in the cycle it appears.

The parameter `NUM_IRQ` is the total interrupt count. It must be a multiple of 32, and the range 64 to 512 is supported. Interrupt IDs 0 to 31 are internal and have no storage in this block. `irq_in[i]` is the input line of interrupt ID 32+i.

Top module: `sgate_irq_bitmaps`

## Requirements
- R1: After reset, every enable, pending, active, group and trigger bit is 0, so every interrupt is level-triggered, and every permission code is 0.
- R2: `req_ready` is always high. A read request is answered with `rsp_valid` high one cycle later. A write request produces no `rsp_valid`.
- R3: Bitmap words use `req_index[7]`=0, with the bank in `req_index[6:4]` and the word in `req_index[3:0]`. Word w covers IDs 32*w to 32*w+31, and bit b of the word is ID 32*w+b. Word 0, and any word whose first ID is at or above `NUM_IRQ`, reads as 0 and ignores writes.
- R4: The banks are: 0 group, 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear, 7 trigger (1 = edge). A 1 written to a set bank sets the bit, and a 1 written to a clear bank clears it. A 0 bit in the write data leaves the state unchanged. Either alias reads the current bitmap.
- R5: The non-secure mask applies to an access with `req_secure`=0 while `sec_disable`=0. Under this mask, the enable banks, writes to the active banks and the trigger bank reach only the bits whose group bit is 1.
- R6: Under the non-secure mask, pending-set reads and writes also reach bits whose permission code is 1 or more. Pending-clear reads and writes also reach bits whose code is 2 or more.
- R7: Under the non-secure mask, reads of either active bank also reach bits whose code is 2 or more. Writes to the active banks use the group bit alone.
- R8: A read of a pending bank returns the pending latch OR (sampled input level AND NOT trigger bit).
- R9: A 0-to-1 change on an input line sets the pending latch only when the trigger bit of that interrupt is 1. A line that holds its level does not set the latch again, and a level-triggered line never sets the latch.
- R10: Permission codes use `req_index[7:5]`=3'b100, with the word c in `req_index[4:0]`. Word c holds IDs 16*c to 16*c+15, and bits [2j+1:2j] hold the code of ID 16*c+j. These words are readable and writable only when `req_secure`=1 and `sec_disable`=0, and are RAZ/WI otherwise. Words holding IDs below 32, or IDs at or above `NUM_IRQ`, are RAZ/WI.
- R11: Under the non-secure mask, the group bank reads as 0 and ignores writes.
- R12: With `sec_disable`=1, every bitmap access reaches every bit whatever the value of `req_secure`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | 1 = single security state, all accesses unrestricted |
| irq_in | input | NUM_IRQ-32 | Shared interrupt lines, bit i is ID 32+i |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the request |
| req_index | input | 8 | Register word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The permission mask is exercised with three kinds of interrupt in the same register word:
- interrupts in the non-secure group;
- secure interrupts with permission codes 1, 2 and 3;
- secure interrupts with code 0.

Issuing the same non-secure write to the set and clear aliases shows which threshold each alias applies. Inputs are driven on both level-triggered and edge-triggered interrupts. Comparing a line that pulses with a line that stays high shows the level fold apart from the latched edge, and shows that a steady line does not re-latch. Word 0, the words past the last interrupt and the `sec_disable` mode are tried against the same stored state, so a wrong range decode or a wrong mode shows up as nonzero data.

// File: rtl/sgate_pkg.sv
package sgate_pkg;

  // Bank selector in req_index[6:4] for bitmap words
  typedef enum logic [2:0] {
    BK_GROUP  = 3'd0,
    BK_EN_SET = 3'd1,
    BK_EN_CLR = 3'd2,
    BK_PD_SET = 3'd3,
    BK_PD_CLR = 3'd4,
    BK_AC_SET = 3'd5,
    BK_AC_CLR = 3'd6,
    BK_TRIG   = 3'd7
  } bank_e;

  // Per-bit permission for one 32-interrupt word
  function automatic logic [31:0] perm_word(input logic open_view,
                                            input logic [31:0] grp,
                                            input logic [31:0] thr);
    return open_view ? 32'hFFFF_FFFF : (grp | thr);
  endfunction

endpackage

// File: rtl/sgate_word_bitmap.sv
module sgate_word_bitmap #(
  parameter int NWORDS = 2,
  parameter int SELW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SELW-1:0]        word_sel,
  input  logic [31:0]            wmask,
  input  logic [31:0]            wdata,
  input  logic [NWORDS*32-1:0]   ext_set,
  output logic [NWORDS*32-1:0]   state_q
);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic        hit;
    logic [31:0] word_q;
    logic [31:0] nxt;

    assign hit = we && (word_sel == SELW'(w));

    always_comb begin
      nxt = word_q;
      if (hit) nxt = (word_q & ~wmask) | (wdata & wmask);
      nxt = nxt | ext_set[w*32 +: 32];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= nxt;
    end

    assign state_q[w*32 +: 32] = word_q;
  end

endmodule

// File: rtl/sgate_code_bank.sv
module sgate_code_bank #(
  parameter int NSPI = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [4:0]          word_sel,
  input  logic [31:0]         wdata,
  output logic [2*NSPI-1:0]   codes_q,
  output logic [NSPI-1:0]     ge1,
  output logic [NSPI-1:0]     ge2
);

  localparam int NCW = NSPI / 16;

  sgate_word_bitmap #(.NWORDS(NCW), .SELW(5)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .word_sel(word_sel),
    .wmask   (32'hFFFF_FFFF),
    .wdata   (wdata),
    .ext_set ('0),
    .state_q (codes_q)
  );

  for (genvar i = 0; i < NSPI; i++) begin : g_thr
    assign ge1[i] = |codes_q[2*i +: 2];
    assign ge2[i] = codes_q[2*i+1];
  end

endmodule

// File: rtl/sgate_line_sampler.sv
module sgate_line_sampler #(
  parameter int NSPI = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSPI-1:0] lines,
  output logic [NSPI-1:0] level_q,
  output logic [NSPI-1:0] rise
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= lines;
  end

  assign rise = lines & ~level_q;

endmodule

// File: rtl/sgate_irq_bitmaps.sv
module sgate_irq_bitmaps
  import sgate_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_disable,
  input  logic [NUM_IRQ-33:0] irq_in,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_secure,
  input  logic [7:0]          req_index,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata
);

  localparam int NSPI   = NUM_IRQ - 32;
  localparam int NWORDS = NSPI / 32;
  localparam int NCW    = NSPI / 16;

  // State vectors, bit i is interrupt ID 32+i
  logic [NSPI-1:0]   grp_q, en_q, pend_q, act_q, trig_q;
  logic [NSPI-1:0]   level_q, rise, ge1, ge2;
  logic [2*NSPI-1:0] codes_q;

  // Decode
  bank_e       bank;
  logic        bm_ok, cb_ok, open_view, cb_access, wr, rd;
  int          kidx, cidx;
  logic [31:0] g_w, e_w, p_w, a_w, t_w, l_w, t1_w, t2_w;
  logic [31:0] m_grp, m_ge1, m_ge2, pend_view, rd_word;

  assign req_ready = 1'b1;
  assign bank      = bank_e'(req_index[6:4]);
  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;
  assign open_view = req_secure || sec_disable;
  assign cb_access = req_secure && !sec_disable;

  assign bm_ok = !req_index[7] && (req_index[3:0] != 4'd0)
              && (int'(req_index[3:0]) <= NWORDS);
  assign cb_ok = (req_index[7:5] == 3'b100) && (int'(req_index[4:0]) >= 2)
              && (int'(req_index[4:0]) - 2 < NCW);
  assign kidx  = bm_ok ? int'(req_index[3:0]) - 1 : 0;
  assign cidx  = cb_ok ? int'(req_index[4:0]) - 2 : 0;

  always_comb begin
    g_w  = grp_q[kidx*32 +: 32];
    e_w  = en_q[kidx*32 +: 32];
    p_w  = pend_q[kidx*32 +: 32];
    a_w  = act_q[kidx*32 +: 32];
    t_w  = trig_q[kidx*32 +: 32];
    l_w  = level_q[kidx*32 +: 32];
    t1_w = ge1[kidx*32 +: 32];
    t2_w = ge2[kidx*32 +: 32];
  end

  assign m_grp     = perm_word(open_view, g_w, 32'h0);
  assign m_ge1     = perm_word(open_view, g_w, t1_w);
  assign m_ge2     = perm_word(open_view, g_w, t2_w);
  assign pend_view = p_w | (l_w & ~t_w);

  // Write controls per bitmap
  logic        grp_we, en_we, pd_we, ac_we, tr_we, cb_we;
  logic [31:0] en_m, pd_m, ac_m;
  logic [31:0] en_d, pd_d, ac_d;

  assign grp_we = wr && bm_ok && (bank == BK_GROUP) && open_view;
  assign en_we  = wr && bm_ok && (bank == BK_EN_SET || bank == BK_EN_CLR);
  assign pd_we  = wr && bm_ok && (bank == BK_PD_SET || bank == BK_PD_CLR);
  assign ac_we  = wr && bm_ok && (bank == BK_AC_SET || bank == BK_AC_CLR);
  assign tr_we  = wr && bm_ok && (bank == BK_TRIG);
  assign cb_we  = wr && cb_ok && cb_access;

  assign en_m = req_wdata & m_grp;
  assign en_d = (bank == BK_EN_SET) ? 32'hFFFF_FFFF : 32'h0;
  assign pd_m = req_wdata & ((bank == BK_PD_SET) ? m_ge1 : m_ge2);
  assign pd_d = (bank == BK_PD_SET) ? 32'hFFFF_FFFF : 32'h0;
  assign ac_m = req_wdata & m_grp;
  assign ac_d = (bank == BK_AC_SET) ? 32'hFFFF_FFFF : 32'h0;

  sgate_word_bitmap #(.NWORDS(NWORDS), .SELW(4)) grp_i (
    .clk(clk), .rst_n(rst_n), .we(grp_we), .word_sel(4'(kidx)),
    .wmask(32'hFFFF_FFFF), .wdata(req_wdata), .ext_set('0), .state_q(grp_q));

  sgate_word_bitmap #(.NWORDS(NWORDS), .SELW(4)) en_i (
    .clk(clk), .rst_n(rst_n), .we(en_we), .word_sel(4'(kidx)),
    .wmask(en_m), .wdata(en_d), .ext_set('0), .state_q(en_q));

  sgate_word_bitmap #(.NWORDS(NWORDS), .SELW(4)) pend_i (
    .clk(clk), .rst_n(rst_n), .we(pd_we), .word_sel(4'(kidx)),
    .wmask(pd_m), .wdata(pd_d), .ext_set(rise & trig_q), .state_q(pend_q));

  sgate_word_bitmap #(.NWORDS(NWORDS), .SELW(4)) act_i (
    .clk(clk), .rst_n(rst_n), .we(ac_we), .word_sel(4'(kidx)),
    .wmask(ac_m), .wdata(ac_d), .ext_set('0), .state_q(act_q));

  sgate_word_bitmap #(.NWORDS(NWORDS), .SELW(4)) trig_i (
    .clk(clk), .rst_n(rst_n), .we(tr_we), .word_sel(4'(kidx)),
    .wmask(m_grp), .wdata(req_wdata), .ext_set('0), .state_q(trig_q));

  sgate_code_bank #(.NSPI(NSPI)) codes_i (
    .clk(clk), .rst_n(rst_n), .we(cb_we), .word_sel(5'(cidx)),
    .wdata(req_wdata), .codes_q(codes_q), .ge1(ge1), .ge2(ge2));

  sgate_line_sampler #(.NSPI(NSPI)) lines_i (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .level_q(level_q), .rise(rise));

  // Read selection
  always_comb begin
    rd_word = 32'h0;
    if (bm_ok) begin
      unique case (bank)
        BK_GROUP:             rd_word = open_view ? g_w : 32'h0;
        BK_EN_SET, BK_EN_CLR: rd_word = e_w & m_grp;
        BK_PD_SET:            rd_word = pend_view & m_ge1;
        BK_PD_CLR:            rd_word = pend_view & m_ge2;
        BK_AC_SET, BK_AC_CLR: rd_word = a_w & m_ge2;
        BK_TRIG:              rd_word = t_w & m_grp;
        default:              rd_word = 32'h0;
      endcase
    end else if (cb_ok && cb_access) begin
      rd_word = codes_q[cidx*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/sgate_irq_bitmaps_chk.sv
module sgate_irq_bitmaps_chk #(
  parameter int NSPI = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sec_disable,
  input logic [NSPI-1:0] irq_in,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_secure,
  input logic [7:0]      req_index,
  input logic            rsp_valid,
  input logic [31:0]     rsp_rdata,
  input logic [NSPI-1:0] pend_q,
  input logic [NSPI-1:0] trig_q,
  input logic [NSPI-1:0] level_q
);

  logic [NSPI-1:0] edge_hit;
  assign edge_hit = irq_in & ~level_q & trig_q;

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_no_rsp_otherwise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_raz_low_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_index[7] && req_index[3:0] == 4'd0)
    |=> (rsp_rdata == 32'h0));

  p_edge_latches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));

  p_pend_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_write && !req_index[7] &&
       (req_index[6:4] == 3'd3 || req_index[6:4] == 3'd4)) && !(|edge_hit))
    |=> $stable(pend_q));

  p_codes_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_index[7:5] == 3'b100 &&
     (!req_secure || sec_disable)) |=> (rsp_rdata == 32'h0));

  p_group_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_index[7] && req_index[6:4] == 3'd0 &&
     !req_secure && !sec_disable) |=> (rsp_rdata == 32'h0));

endmodule

bind sgate_irq_bitmaps sgate_irq_bitmaps_chk #(.NSPI(NSPI)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_disable(sec_disable),
  .irq_in     (irq_in),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_secure (req_secure),
  .req_index  (req_index),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .pend_q     (pend_q),
  .trig_q     (trig_q),
  .level_q    (level_q)
);

// File: tb/sgate_irq_bitmaps_tb_top.sv
module sgate_irq_bitmaps_tb_top;

  localparam int NUM_IRQ = 96;
  localparam int NSPI    = NUM_IRQ - 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sec_disable = 1'b0;
  logic [NSPI-1:0] irq_in = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic            req_secure = 1'b0;
  logic [7:0]      req_index = 8'h0;
  logic [31:0]     req_wdata = 32'h0;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  sgate_irq_bitmaps #(.NUM_IRQ(NUM_IRQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_secure(req_secure), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  // Monitor: compare each response with the queued expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected response: actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic drive(input bit w, input bit sec, input logic [7:0] idx,
                       input logic [31:0] d);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = w;
    req_secure = sec;
    req_index  = idx;
    req_wdata  = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input bit sec, input logic [7:0] idx,
                    input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    drive(1'b0, sec, idx, 32'h0);
  endtask

  task automatic wr(input bit sec, input logic [7:0] idx, input logic [31:0] d);
    drive(1'b1, sec, idx, d);
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2 write answered: actual=%b expected=0", rsp_valid);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam bit S = 1'b1;
  localparam bit N = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, R2 ready
    total++;
    if (req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R2 ready: actual=%b expected=1", req_ready);
    end
    rd(S, 8'h11, 32'h0, "R1 enable after reset");
    rd(S, 8'h31, 32'h0, "R1 pending after reset");
    rd(S, 8'h71, 32'h0, "R1 trigger after reset");
    rd(S, 8'h82, 32'h0, "R1 codes after reset");

    // R4 set / clear aliases
    wr(S, 8'h11, 32'h0000_00F0);
    rd(S, 8'h11, 32'h0000_00F0, "R4 enable set");
    rd(S, 8'h21, 32'h0000_00F0, "R4 clear alias reads bitmap");
    wr(S, 8'h11, 32'h0);
    wr(S, 8'h21, 32'h0000_0030);
    rd(S, 8'h11, 32'h0000_00C0, "R4 enable clear");
    wr(S, 8'h21, 32'h0);
    rd(S, 8'h11, 32'h0000_00C0, "R4 zero clear no effect");

    // R3 word range
    wr(S, 8'h10, 32'hFFFF_FFFF);
    rd(S, 8'h10, 32'h0, "R3 internal word");
    wr(S, 8'h13, 32'hFFFF_FFFF);
    rd(S, 8'h13, 32'h0, "R3 word past last");
    rd(S, 8'h11, 32'h0000_00C0, "R3 neighbour untouched");
    rd(S, 8'h12, 32'h0, "R3 word two untouched");

    // R11 group register
    wr(N, 8'h01, 32'hFFFF_FFFF);
    rd(S, 8'h01, 32'h0, "R11 ns group write ignored");
    wr(S, 8'h01, 32'h0000_FF00);
    rd(S, 8'h01, 32'h0000_FF00, "R11 secure group write");
    rd(N, 8'h01, 32'h0, "R11 ns group reads zero");

    // R5 group-only mask on enables
    wr(N, 8'h11, 32'hFFFF_FFFF);
    rd(S, 8'h11, 32'h0000_FFC0, "R5 ns enable set masked");
    rd(N, 8'h11, 32'h0000_FF00, "R5 ns enable read masked");
    wr(N, 8'h21, 32'h0000_01C0);
    rd(S, 8'h11, 32'h0000_FEC0, "R5 ns enable clear masked");

    // R10 permission codes: ID32=1, ID33=2, ID34=3
    wr(S, 8'h82, 32'h0000_0039);
    rd(S, 8'h82, 32'h0000_0039, "R10 code write");
    rd(N, 8'h82, 32'h0, "R10 ns code read");
    wr(N, 8'h82, 32'hFFFF_FFFF);
    rd(S, 8'h82, 32'h0000_0039, "R10 ns code write ignored");
    wr(S, 8'h80, 32'h0000_00FF);
    rd(S, 8'h80, 32'h0, "R10 internal code word");

    // R6 pending thresholds
    wr(N, 8'h31, 32'h0000_000F);
    rd(S, 8'h31, 32'h0000_0007, "R6 ns pend set needs code>=1");
    rd(N, 8'h31, 32'h0000_0007, "R6 ns pend-set view");
    rd(N, 8'h41, 32'h0000_0006, "R6 ns pend-clear view code>=2");
    wr(N, 8'h41, 32'h0000_0007);
    rd(S, 8'h31, 32'h0000_0001, "R6 ns pend clear needs code>=2");

    // R7 active
    wr(N, 8'h51, 32'h0000_FFFF);
    wr(S, 8'h51, 32'h0000_0006);
    rd(N, 8'h51, 32'h0000_FF06, "R7 ns active read");
    wr(S, 8'h51, 32'h0000_0001);
    rd(N, 8'h61, 32'h0000_FF06, "R7 code 1 hidden from ns");
    wr(N, 8'h61, 32'h0000_000F);
    rd(S, 8'h51, 32'h0000_FF07, "R7 ns active write group only");
    wr(S, 8'h61, 32'h0000_FFFF);
    rd(S, 8'h51, 32'h0, "R7 secure active clear");

    // R8 level fold on ID40 (word 1 bit 8)
    irq_in[8] = 1'b1;
    idle(2);
    rd(S, 8'h31, 32'h0000_0101, "R8 level folds into pending");
    irq_in[8] = 1'b0;
    idle(2);
    rd(S, 8'h31, 32'h0000_0001, "R9 level line not latched");

    // R9 edge latch
    wr(S, 8'h71, 32'h0000_0100);
    rd(S, 8'h71, 32'h0000_0100, "R4 trigger write");
    irq_in[8] = 1'b1;
    idle(2);
    rd(S, 8'h31, 32'h0000_0101, "R9 rising edge latches");
    irq_in[8] = 1'b0;
    idle(2);
    rd(S, 8'h31, 32'h0000_0101, "R9 latch held after drop");
    wr(S, 8'h41, 32'h0000_0100);
    rd(S, 8'h31, 32'h0000_0001, "R9 latch cleared");
    irq_in[8] = 1'b1;
    idle(2);
    wr(S, 8'h41, 32'h0000_0100);
    idle(2);
    rd(S, 8'h31, 32'h0000_0001, "R9 steady high no relatch");
    irq_in[8] = 1'b0;
    idle(1);

    // R3 / R10 upper boundary
    wr(S, 8'h12, 32'h8000_0000);
    rd(S, 8'h12, 32'h8000_0000, "R3 last interrupt");
    wr(S, 8'h85, 32'hC000_0000);
    rd(S, 8'h85, 32'hC000_0000, "R10 last code word");
    wr(S, 8'h86, 32'hFFFF_FFFF);
    rd(S, 8'h86, 32'h0, "R10 code word past last");

    // R12 single security state
    @(negedge clk);
    sec_disable = 1'b1;
    rd(N, 8'h01, 32'h0000_FF00, "R12 group visible");
    wr(N, 8'h11, 32'h0000_0001);
    rd(N, 8'h11, 32'h0000_FEC1, "R12 ns enable any bit");
    wr(N, 8'h41, 32'h0000_0001);
    rd(N, 8'h31, 32'h0, "R12 ns pend clear any bit");
    rd(S, 8'h82, 32'h0, "R10 codes hidden when disabled");

    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule